// File: doc/BRIEF.md
# Int8 Block Dot-Product Pipeline

This block takes one block of 32 signed 8-bit weights and 32 signed 8-bit activations, forms their dot product exactly in 24-bit integer arithmetic, and multiplies that integer by a single-precision scale factor. The result is one IEEE-754 single-precision value per block. It is the inner step of a quantized matrix-vector product: the caller supplies one block and its scale per accepted transfer, and it sums the scaled block results elsewhere.

Internally, four identical multiply-accumulate lanes each use a paired primitive. That primitive multiplies two signed byte pairs and adds both products into one sign-extended 24-bit value. The lanes run over two passes of sixteen elements. The eight partial sums of the two passes are joined by paired 24-bit adders. The result then moves through a fixed twelve-stage integer chain. Only after that chain is the integer converted to floating point and multiplied by the scale. The latency is fixed. A new block can be accepted every second cycle.

Top module: `int8_block_dot`

## Requirements
- R1: A block, with its scale, is taken on a rising clock edge where `inValid` and `inReady` are both high. `inReady` is low for exactly the one cycle after such an edge and high otherwise. `inValid` has no effect while `inReady` is low.
- R2: Element k (k = 0..31) is the two's-complement byte at bits [8k+7:8k] of `wgtBlk` and of `actBlk`. The result equals the product of scale and the sum over k of weight k times activation k.
- R3: The integer sum is exact for every input, including all weights and activations at -128. In that case the sum is 524288, and with a scale of 1.0 the result is 0x49000000.
- R4: The integer converts to floating point without error. A zero sum gives a zero result whose sign bit is the sign bit of the scale.
- R5: The final multiply rounds to nearest, with ties going to the even significand.
- R6: A subnormal scale is treated as zero, so the result is a zero with the XOR of both signs. No result is ever subnormal: products below the normal range become signed zero.
- R7: A NaN scale gives 0x7FC00000. An infinite scale times a zero sum gives 0x7FC00000. An infinite scale times a nonzero sum gives infinity with the XOR of both signs. A product above the largest finite value gives infinity.
- R8: `outValid` is high for one cycle, fourteen rising edges after the edge that accepted the block, and `outResult` carries that block's result in the same cycle.
- R9: Blocks accepted on every second edge each produce their own result, in the order they were accepted.
- R10: While `rstN` is low, `outValid` is 0, `outResult` is 0 and `inReady` is 1. Blocks in flight at reset produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A block and its scale are presented |
| inReady | output | 1 | The block can take a new input on this edge |
| wgtBlk | input | 256 | 32 packed signed weight bytes, element k at bits [8k+7:8k] |
| actBlk | input | 256 | 32 packed signed activation bytes, same packing |
| scale | input | 32 | Single-precision scale factor |
| outValid | output | 1 | `outResult` holds a block result |
| outResult | output | 32 | Single-precision scaled dot product |

## Verification
Integer state held by the wrong pass, the wrong lane or the wrong tree level shows up as a wrong `outResult` for that block. This happens exactly fourteen edges after acceptance, so each vector's result is compared against a bench model of exact integer sum times scale. A scale that slips out of step with its data shows up when back-to-back blocks with distinct scales are issued. A control slip is caught on the very next edge: a missing busy cycle after acceptance, or a valid tag lost or duplicated in the chain. It appears as `inReady` staying high, as an output with no accepted block behind it, or as an output on the wrong edge.

// File: rtl/bdot_pkg.sv
package bdot_pkg;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic capture;   // latch the presented block and scale
    logic pass0;     // multiply the first half of the block
    logic pass1;     // multiply the second half and join with the first
  } dotStrobe_t;

  localparam logic [31:0] FP_QNAN = 32'h7FC0_0000;
  localparam int          FP_BIAS = 127;

endpackage

// File: rtl/bdot_ctrl.sv
module bdot_ctrl
  import bdot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output dotStrobe_t strb
);

  logic pass0Q;
  logic pass1Q;
  logic accept;

  // The busy cycle after an accept is the first pass cycle, so a new
  // block can enter on the edge that ends the second pass.
  assign inReady = !pass0Q;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pass0Q <= 1'b0;
      pass1Q <= 1'b0;
    end else begin
      pass0Q <= accept;
      pass1Q <= pass0Q;
    end
  end

  always_comb begin
    strb.capture = accept;
    strb.pass0   = pass0Q;
    strb.pass1   = pass1Q;
  end

endmodule

// File: rtl/bdot_datapath.sv
module bdot_datapath
  import bdot_pkg::*;
#(
  parameter int ELEMS        = 32,
  parameter int LANES        = 4,
  parameter int ACC_W        = 24,
  parameter int CHAIN_STAGES = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  dotStrobe_t          strb,
  input  logic [ELEMS*8-1:0]  wgtBlk,
  input  logic [ELEMS*8-1:0]  actBlk,
  input  logic [31:0]         scale,
  output logic                sumVld,
  output logic [ACC_W-1:0]    sumOut,
  output logic [31:0]         sumScale
);

  localparam int BLK_W      = ELEMS * 8;
  localparam int PASSES     = 2;
  localparam int PASS_ELEMS = ELEMS / PASSES;
  localparam int PAIRS      = PASS_ELEMS / (LANES * 2);
  localparam int NSUM       = LANES * PAIRS;
  localparam int LVLS       = $clog2(NSUM);
  localparam int TREE_N     = 2 * NSUM - 1;
  localparam int PAD        = CHAIN_STAGES - 2 - LVLS;
  localparam int SC_LEN     = LVLS + PAD + 1;

  // Operand registers, loaded on accept.
  logic [BLK_W-1:0] wReg;
  logic [BLK_W-1:0] aReg;
  logic [31:0]      scaleIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg    <= '0;
      aReg    <= '0;
      scaleIn <= '0;
    end else if (strb.capture) begin
      wReg    <= wgtBlk;
      aReg    <= actBlk;
      scaleIn <= scale;
    end
  end

  // Paired signed byte multiply, both products summed into a 24-bit lane.
  function automatic logic [ACC_W-1:0] pairMac(input logic [15:0] w, input logic [15:0] a);
    logic signed [ACC_W-1:0] w0, w1, a0, a1;
    w0 = ACC_W'($signed(w[7:0]));
    w1 = ACC_W'($signed(w[15:8]));
    a0 = ACC_W'($signed(a[7:0]));
    a1 = ACC_W'($signed(a[15:8]));
    return w0 * a0 + w1 * a1;
  endfunction

  function automatic int lvlOff(input int l);
    int o;
    o = 0;
    for (int k = 0; k < l; k++) o += NSUM >> k;
    return o;
  endfunction

  // Stage 1 and 2: lane products for the active pass.
  logic [NSUM-1:0][ACC_W-1:0] passProd;
  logic [NSUM-1:0][ACC_W-1:0] mulA;

  always_comb begin
    int base;
    base = strb.pass1 ? PASS_ELEMS : 0;
    for (int s = 0; s < NSUM; s++) begin
      passProd[s] = pairMac(wReg[(base + 2 * s) * 8 +: 16], aReg[(base + 2 * s) * 8 +: 16]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulA <= '0;
    end else if (strb.pass0) begin
      mulA <= passProd;
    end
  end

  // Level 0 of the tree holds the joined pass sums; each further level
  // halves the count with paired 24-bit adders.
  logic [TREE_N*ACC_W-1:0] treeFlat;
  logic [LVLS:0]           treeVld;
  logic [SC_LEN-1:0][31:0] scaleLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      treeFlat  <= '0;
      treeVld   <= '0;
      scaleLine <= '0;
    end else begin
      treeVld[0] <= strb.pass1;
      if (strb.pass1) begin
        for (int s = 0; s < NSUM; s++) begin
          treeFlat[s * ACC_W +: ACC_W] <= mulA[s] + passProd[s];
        end
        scaleLine[0] <= scaleIn;
      end
      for (int l = 1; l <= LVLS; l++) begin
        treeVld[l] <= treeVld[l-1];
        for (int i = 0; i < NSUM; i++) begin
          if (i < (NSUM >> l)) begin
            treeFlat[(lvlOff(l) + i) * ACC_W +: ACC_W] <=
              treeFlat[(lvlOff(l-1) + 2 * i) * ACC_W +: ACC_W] +
              treeFlat[(lvlOff(l-1) + 2 * i + 1) * ACC_W +: ACC_W];
          end
        end
      end
      for (int i = 1; i < SC_LEN; i++) begin
        scaleLine[i] <= scaleLine[i-1];
      end
    end
  end

  // Remaining integer stages of the fixed chain.
  logic [PAD-1:0][ACC_W-1:0] padData;
  logic [PAD-1:0]            padVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padData <= '0;
      padVld  <= '0;
    end else begin
      padData[0] <= treeFlat[(TREE_N - 1) * ACC_W +: ACC_W];
      padVld[0]  <= treeVld[LVLS];
      for (int i = 1; i < PAD; i++) begin
        padData[i] <= padData[i-1];
        padVld[i]  <= padVld[i-1];
      end
    end
  end

  assign sumOut   = padData[PAD-1];
  assign sumVld   = padVld[PAD-1];
  assign sumScale = scaleLine[SC_LEN-1];

endmodule

// File: rtl/bdot_fpscale.sv
module bdot_fpscale
  import bdot_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sumVld,
  input  logic [ACC_W-1:0] sumIn,
  input  logic [31:0]      scaleIn,
  output logic             resVld,
  output logic [31:0]      result
);

  // Exact integer to single precision (ACC_W up to 24 bits).
  logic [31:0] convF;
  always_comb begin
    logic             sgn;
    logic [ACC_W-1:0] mag;
    logic [23:0]      norm;
    int               pos;
    sgn = sumIn[ACC_W-1];
    mag = sgn ? (~sumIn + 1'b1) : sumIn;
    pos = 0;
    for (int i = 0; i < ACC_W; i++) begin
      if (mag[i]) pos = i;
    end
    norm = 24'(mag) << (23 - pos);
    if (mag == '0) convF = 32'h0;
    else           convF = {sgn, 8'(FP_BIAS + pos), norm[22:0]};
  end

  logic [31:0] convQ;
  logic [31:0] scaleQ;
  logic        convVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convQ   <= '0;
      scaleQ  <= '0;
      convVld <= 1'b0;
    end else begin
      convQ   <= convF;
      scaleQ  <= scaleIn;
      convVld <= sumVld;
    end
  end

  // Single-precision multiply: nearest-even, subnormals flushed,
  // specials of the scale passed on. The converted operand is never
  // subnormal, infinite or NaN.
  function automatic logic [31:0] fpMul(input logic [31:0] a, input logic [31:0] b);
    logic        s, g, st, bNan, bInf;
    logic [47:0] prod;
    logic [22:0] m;
    logic [23:0] mr;
    int          ex;
    s    = a[31] ^ b[31];
    bNan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    bInf = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (bNan) return FP_QNAN;
    if (bInf) return (a[30:23] == 0) ? FP_QNAN : {s, 8'hFF, 23'h0};
    if (a[30:23] == 0 || b[30:23] == 0) return {s, 31'h0};
    prod = {1'b1, a[22:0]} * {1'b1, b[22:0]};
    ex   = int'(a[30:23]) + int'(b[30:23]) - FP_BIAS;
    if (prod[47]) begin
      m  = prod[46:24];
      g  = prod[23];
      st = |prod[22:0];
      ex = ex + 1;
    end else begin
      m  = prod[45:23];
      g  = prod[22];
      st = |prod[21:0];
    end
    mr = {1'b0, m} + 24'(g & (st | m[0]));
    if (mr[23]) ex = ex + 1;
    if (ex >= 255) return {s, 8'hFF, 23'h0};
    if (ex <= 0)   return {s, 31'h0};
    return {s, 8'(ex), mr[22:0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      resVld <= 1'b0;
    end else begin
      result <= convVld ? fpMul(convQ, scaleQ) : 32'h0;
      resVld <= convVld;
    end
  end

endmodule

// File: rtl/int8_block_dot.sv
module int8_block_dot
  import bdot_pkg::*;
#(
  parameter int ELEMS        = 32,
  parameter int LANES        = 4,
  parameter int ACC_W        = 24,
  parameter int CHAIN_STAGES = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ELEMS*8-1:0] wgtBlk,
  input  logic [ELEMS*8-1:0] actBlk,
  input  logic [31:0]        scale,
  output logic               outValid,
  output logic [31:0]        outResult
);

  dotStrobe_t       strb;
  logic             sumVld;
  logic [ACC_W-1:0] sumOut;
  logic [31:0]      sumScale;

  bdot_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb)
  );

  bdot_datapath #(
    .ELEMS        (ELEMS),
    .LANES        (LANES),
    .ACC_W        (ACC_W),
    .CHAIN_STAGES (CHAIN_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wgtBlk   (wgtBlk),
    .actBlk   (actBlk),
    .scale    (scale),
    .sumVld   (sumVld),
    .sumOut   (sumOut),
    .sumScale (sumScale)
  );

  bdot_fpscale #(
    .ACC_W (ACC_W)
  ) u_fp (
    .clk     (clk),
    .rstN    (rstN),
    .sumVld  (sumVld),
    .sumIn   (sumOut),
    .scaleIn (sumScale),
    .resVld  (outValid),
    .result  (outResult)
  );

endmodule

// File: rtl/bdot_chk.sv
module bdot_chk #(
  parameter int LAT = 14
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic [31:0] outResult
);

  // hist[j] holds whether a block was accepted j edges ago.
  logic [LAT:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hist <= '0;
    else       hist <= {hist[LAT-1:0], inValid && inReady};
  end

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R1
  ready_returns_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady);

  // R8
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == hist[LAT]);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outResult[30:23] != 8'h00 || outResult[22:0] == 23'h0));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (!outValid && inReady && outResult == 32'h0));

endmodule

bind int8_block_dot bdot_chk #(.LAT(CHAIN_STAGES + 2)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/int8_block_dot_tb_top.sv
`timescale 1ns/1ps
module int8_block_dot_tb_top;

  localparam int ELEMS = 32;
  localparam int BLK_W = ELEMS * 8;
  localparam int LAT   = 14;
  localparam int QLEN  = 64;

  typedef struct packed {
    logic [3:0]  pat;
    logic [31:0] seed;
    logic [31:0] scl;
    logic [7:0]  req;
  } vec_t;

  // pat 0: all -128 | 1: w=k-16, a=3 | 2: w=-128, a=127
  // pat 3: pseudo-random from seed | 4: all zero | 5: w0=seed byte, a0=1
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 32'd0,      32'h3F80_0000, 8'd3},  // R3 extreme, 2^19
    '{4'd1, 32'd0,      32'h3F00_0000, 8'd2},  // R2 ramp, -24.0
    '{4'd2, 32'd0,      32'h3FC0_0000, 8'd3},  // R3 -520192*1.5
    '{4'd3, 32'd1,      32'h3DCC_CCCD, 8'd5},  // R5
    '{4'd3, 32'hBEEF,   32'hC2F6_E979, 8'd5},  // R5
    '{4'd3, 32'd7,      32'h3FFF_FFFF, 8'd5},  // R5
    '{4'd4, 32'd0,      32'hC000_0000, 8'd4},  // R4 -> -0
    '{4'd4, 32'd0,      32'h4000_0000, 8'd4},  // R4 -> +0
    '{4'd5, 32'd3,      32'h3F80_0001, 8'd5},  // R5 tie, rounds up to even
    '{4'd5, 32'd3,      32'h3F80_0003, 8'd5},  // R5 tie, stays even
    '{4'd3, 32'd99,     32'h0040_0000, 8'd6},  // R6 subnormal scale
    '{4'd5, 32'd4,      32'h7F00_0000, 8'd7},  // R7 overflow
    '{4'd1, 32'd0,      32'h7F80_0000, 8'd7},  // R7 -inf
    '{4'd4, 32'd0,      32'hFF80_0000, 8'd7},  // R7 0*inf
    '{4'd3, 32'd5,      32'h7FA0_0000, 8'd7},  // R7 NaN scale
    '{4'd5, 32'h80,     32'h3F80_0000, 8'd2}   // R2 single -128
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid;
  logic             inReady;
  logic [BLK_W-1:0] wgtBlk;
  logic [BLK_W-1:0] actBlk;
  logic [31:0]      scale;
  logic             outValid;
  logic [31:0]      outResult;

  always #2.5 clk = ~clk;

  int8_block_dot dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .wgtBlk    (wgtBlk),
    .actBlk    (actBlk),
    .scale     (scale),
    .outValid  (outValid),
    .outResult (outResult)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycCnt  = 0;
  bit done    = 1'b0;

  logic [31:0] expQ   [QLEN];
  int          expCyc [QLEN];
  int          expReq [QLEN];
  int          wrIdx = 0;
  int          rdIdx = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic void genBlock(input logic [3:0] pat, input logic [31:0] seed,
                                   output logic [BLK_W-1:0] w, output logic [BLK_W-1:0] a);
    logic [31:0] x;
    x = seed | 32'h1;
    w = '0;
    a = '0;
    for (int k = 0; k < ELEMS; k++) begin
      case (pat)
        4'd0: begin w[k*8 +: 8] = 8'h80; a[k*8 +: 8] = 8'h80; end
        4'd1: begin w[k*8 +: 8] = 8'(k - 16); a[k*8 +: 8] = 8'd3; end
        4'd2: begin w[k*8 +: 8] = 8'h80; a[k*8 +: 8] = 8'h7F; end
        4'd3: begin
          x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
          w[k*8 +: 8] = x[7:0];
          a[k*8 +: 8] = x[23:16];
        end
        4'd5: if (k == 0) begin w[7:0] = seed[7:0]; a[7:0] = 8'd1; end
        default: ;
      endcase
    end
  endfunction

  function automatic int refSum(input logic [BLK_W-1:0] w, input logic [BLK_W-1:0] a);
    int s;
    s = 0;
    for (int k = 0; k < ELEMS; k++) s += int'($signed(w[k*8 +: 8])) * int'($signed(a[k*8 +: 8]));
    return s;
  endfunction

  // Exact integer times scale, rounded once to single precision.
  function automatic logic [31:0] refMul(input int sum, input logic [31:0] sc);
    logic        sgn;
    int          e, msb, be, sh;
    longint      p, kept, rem, half;
    sgn = (sum < 0) ^ sc[31];
    e   = int'(sc[30:23]);
    if (e == 255 && sc[22:0] != 0) return 32'h7FC0_0000;
    if (e == 255) return (sum == 0) ? 32'h7FC0_0000 : {sgn, 8'hFF, 23'h0};
    if (sum == 0 || e == 0) return {sgn, 31'h0};
    p = longint'((sum < 0) ? -sum : sum) * longint'({1'b1, sc[22:0]});
    msb = 0;
    for (int i = 0; i < 63; i++) if (p[i]) msb = i;
    be = msb + e - 23 - 127 + 127 - 23 + 23;
    be = msb + e - 23;
    sh = msb - 23;
    if (sh > 0) begin
      kept = p >>> sh;
      rem  = p & ((longint'(1) <<< sh) - 1);
      half = longint'(1) <<< (sh - 1);
      if (rem > half || (rem == half && kept[0])) kept = kept + 1;
      if (kept == (longint'(1) <<< 24)) begin kept = kept >>> 1; be = be + 1; end
    end else begin
      kept = p;
    end
    if (be >= 255) return {sgn, 8'hFF, 23'h0};
    if (be <= 0)   return {sgn, 31'h0};
    return {sgn, 8'(be), kept[22:0]};
  endfunction

  task automatic sendBlock(input logic [BLK_W-1:0] w, input logic [BLK_W-1:0] a,
                           input logic [31:0] sc, input int req);
    @(negedge clk);
    inValid = 1'b1;
    wgtBlk  = w;
    actBlk  = a;
    scale   = sc;
    while (!inReady) @(negedge clk);
    expQ[wrIdx % QLEN]   = refMul(refSum(w, a), sc);
    expCyc[wrIdx % QLEN] = cycCnt + 1;
    expReq[wrIdx % QLEN] = req;
    wrIdx++;
    @(negedge clk);
    check(inReady == 1'b0, 1, 32'(inReady), 32'h0);  // R1 busy after accept
  endtask

  // Result monitor: value against the model (R2..R7), timing (R8).
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rdIdx >= wrIdx) begin
        check(1'b0, 9, outResult, 32'h0);  // R9 output with no accepted block
      end else begin
        check(outResult == expQ[rdIdx % QLEN], expReq[rdIdx % QLEN], outResult, expQ[rdIdx % QLEN]);
        check(cycCnt == expCyc[rdIdx % QLEN] + LAT, 8, 32'(cycCnt), 32'(expCyc[rdIdx % QLEN] + LAT));
        rdIdx++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", wrIdx - rdIdx, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [BLK_W-1:0] w, a;
    inValid = 1'b0;
    wgtBlk  = '0;
    actBlk  = '0;
    scale   = '0;

    // R10 reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, 10, 32'(outValid), 32'h0);
    check(outResult == 32'h0, 10, outResult, 32'h0);
    check(inReady == 1'b1, 10, 32'(inReady), 32'h1);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, 1, 32'(inReady), 32'h1);

    // Table walk, one block at a time
    for (int v = 0; v < NV; v++) begin
      genBlock(VECS[v].pat, VECS[v].seed, w, a);
      sendBlock(w, a, VECS[v].scl, int'(VECS[v].req));
      inValid = 1'b0;
      repeat (LAT + 3) @(negedge clk);
    end

    // R9 back-to-back blocks, each with its own scale, in order
    for (int b = 0; b < 6; b++) begin
      genBlock(4'd3, 32'(100 + b), w, a);
      sendBlock(w, a, 32'h3F80_0000 + 32'(b << 20), 9);
    end
    inValid = 1'b0;
    repeat (LAT + 8) @(negedge clk);
    check(rdIdx == wrIdx, 9, 32'(rdIdx), 32'(wrIdx));

    // R10 reset with a block in flight: its result never appears
    genBlock(4'd0, 32'd0, w, a);
    sendBlock(w, a, 32'h3F80_0000, 10);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    rstN  = 1'b0;
    rdIdx = wrIdx;
    @(negedge clk);
    check(outValid == 1'b0, 10, 32'(outValid), 32'h0);
    check(inReady == 1'b1, 10, 32'(inReady), 32'h1);
    rstN = 1'b1;
    repeat (LAT + 6) @(negedge clk);
    check(rdIdx == wrIdx, 10, 32'(rdIdx), 32'(wrIdx));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule